// File: doc/BRIEF.md
# Host Word FIFO to DMA Drain Bridge

This block sits between a host bus and a destination memory. The host writes 16-bit words into a small FIFO through a data register. It enables the transfer through a control register and sets a transfer length in a length register. A DMA channel on the processor side supplies a mode field, a master enable, a source address, a destination address and a transfer count. When the channel is armed, the block drains the FIFO four words at a time onto a 16-bit memory write port. Each word goes out with a valid/ready handshake, one per clock when the sink is ready.

Every word that is written out advances the destination address by two and decrements both the channel count and the shared length. The drain ends the host transfer when the length runs out and flags a normal channel end when the count runs out. A processor write to the channel's count or operation register can also start a drain. It does so only when the channel source address points at the FIFO port and the FIFO holds a non-zero multiple of four words.

Top module: `hfifo_bridge`

## Requirements
- R1: After reset, status_o, len_o, chan_cnt_o, chan_end_o, anomaly_o and mem_valid_o are all zero.
- R2: A host write with host_sel_i = 1 (length) stores host_wdata_i into len_o with bits 1:0 forced to zero.
- R3: A host write with host_sel_i = 2 (data) while the enable bit is clear is discarded: the word never reaches the memory port, and anomaly_o is high for the cycle after the write.
- R4: Drained words appear on the memory port in arrival order at chan_dst, chan_dst+2, chan_dst+4, and so on. While mem_ready_i is low, mem_valid_o, mem_addr_o and mem_data_o hold steady.
- R5: A drain starts when an accepted data write brings the fill count to a multiple of four, but only while chan_mode_i = 1 and chan_en_i = 1. Otherwise the words stay in the FIFO.
- R6: Each handshaked word decrements chan_cnt_o and len_o. The drain stops when the FIFO is empty or chan_cnt_o reaches zero. Any words left over are discarded, and the FIFO is emptied.
- R7: Status bit 7 (full) sets when the fill count reaches DEPTH. Data writes while the FIFO is full or a drain is running are ignored. The bit clears when a drain ends.
- R8: When len_o is zero at the end of a drain, status bit 0 (enable) clears.
- R9: When chan_cnt_o reaches zero during a drain, chan_end_o sets. A channel load (chan_load_i) clears chan_end_o and loads the destination address and count.
- R10: A host write with host_sel_i = 0 (control) sets status bit 0 (enable) from host_wdata_i bit 0 and status bit 1 (direction) from host_wdata_i bit 1. It leaves the full bit unchanged.
- R11: A chan_kick_i pulse starts a drain only if chan_src_i equals FIFO_PORT_ADDR, the fill count is a non-zero multiple of four and the channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 2 | Host register select: 0 control, 1 length, 2 data |
| host_wdata_i | input | 16 | Host write data |
| status_o | output | 16 | Bit 0 enable, bit 1 direction, bit 7 full |
| len_o | output | 16 | Shared transfer length |
| anomaly_o | output | 1 | Pulse for a data write without enable |
| chan_mode_i | input | 2 | Channel mode field; 1 selects host-request transfers |
| chan_en_i | input | 1 | Channel master enable |
| chan_src_i | input | AW | Channel source address |
| chan_load_i | input | 1 | Load destination and count |
| chan_dst_i | input | AW | Destination address to load |
| chan_cnt_i | input | CNTW | Transfer count to load |
| chan_kick_i | input | 1 | Processor wrote count or operation register |
| chan_dst_o | output | AW | Current destination address |
| chan_cnt_o | output | CNTW | Remaining transfer count |
| chan_end_o | output | 1 | Normal channel end flag |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory write accepted |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | 16 | Memory write data |

## Verification
The drain is tried with a sink that is always ready and with one that stalls every other cycle, so that ordering and address stepping are checked under backpressure. The bench runs three kinds of transfer: one that ends on an empty FIFO, one where the length runs out first, and one where the channel count runs out first and discards leftovers. These show which of the two counters ends the transfer and which flag each one raises. The bench then fills the FIFO while the channel is not armed. It kicks once with a wrong source address and once with the correct one, which separates the write-triggered start from the processor-triggered start and shows that overflow words are dropped.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_RUN  = 1'b1
  } drain_state_e;

  localparam logic [1:0] MODE_HOST_REQ = 2'd1;
  localparam int STAT_EN_BIT   = 0;
  localparam int STAT_DIR_BIT  = 1;
  localparam int STAT_FULL_BIT = 7;
endpackage

// File: rtl/hfb_word_store.sv
module hfb_word_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          clear_i,
  output logic [CW-1:0] fill_o,
  output logic [DW-1:0] head_o,
  output logic          last_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] fill_q, rd_q;
  logic          full_q;
  logic [CW-1:0] fill_inc;

  assign fill_inc = fill_q + CW'(1);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[fill_q[IW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else if (clear_i) begin
      fill_q <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (push_i) begin
        fill_q <= fill_inc;
        if (fill_inc == CW'(DEPTH)) full_q <= 1'b1;
      end
      if (pop_i) rd_q <= rd_q + CW'(1);
    end
  end

  assign fill_o = fill_q;
  assign head_o = mem_q[rd_q[IW-1:0]];
  assign last_o = (rd_q + CW'(1)) == fill_q;
  assign full_o = full_q;
endmodule

// File: rtl/hfb_chan_regs.sv
module hfb_chan_regs #(
  parameter int AW   = 32,
  parameter int CNTW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            step_i,
  input  logic            finish_i,
  output logic [AW-1:0]   dst_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            end_o
);
  logic [AW-1:0]   dst_q;
  logic [CNTW-1:0] cnt_q, cnt_after;
  logic            end_q;

  assign cnt_after = step_i ? cnt_q - CNTW'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      if (load_i) begin
        dst_q <= dst_i;
        cnt_q <= cnt_i;
        end_q <= 1'b0;
      end
      if (step_i) begin
        dst_q <= dst_q + AW'(2);
        cnt_q <= cnt_after;
      end
      if (finish_i && cnt_after == '0) end_q <= 1'b1;
    end
  end

  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign end_o = end_q;
endmodule

// File: rtl/hfb_drain_fsm.sv
module hfb_drain_fsm
  import hfb_pkg::*;
#(
  parameter int CW   = 3,
  parameter int CNTW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [CW-1:0]   fill_i,
  input  logic            kick_i,
  input  logic            src_hit_i,
  input  logic            armed_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            last_i,
  input  logic            mem_ready_i,
  output logic            busy_o,
  output logic            mem_valid_o,
  output logic            pop_o,
  output logic            finish_o
);
  drain_state_e state_q;
  logic [CW-1:0] fill_inc;
  logic wr_trig, kick_trig, cnt_zero, cnt_one;

  assign fill_inc  = fill_i + CW'(1);
  assign wr_trig   = push_i && (fill_inc[1:0] == 2'b00) && armed_i;
  // processor-side start: source must point at the FIFO port
  assign kick_trig = kick_i && src_hit_i && armed_i &&
                     (fill_i != '0) && (fill_i[1:0] == 2'b00);
  assign cnt_zero  = cnt_i == '0;
  assign cnt_one   = cnt_i == CNTW'(1);

  assign busy_o      = state_q == DR_RUN;
  assign mem_valid_o = busy_o && !cnt_zero;
  assign pop_o       = mem_valid_o && mem_ready_i;
  assign finish_o    = busy_o && (cnt_zero || (pop_o && (last_i || cnt_one)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DR_IDLE;
    else begin
      unique case (state_q)
        DR_IDLE: if (wr_trig || kick_trig) state_q <= DR_RUN;
        DR_RUN:  if (finish_o) state_q <= DR_IDLE;
        default: state_q <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfifo_bridge.sv
module hfifo_bridge
  import hfb_pkg::*;
#(
  parameter int          DW             = 16,
  parameter int          DEPTH          = 4,
  parameter int          AW             = 32,
  parameter int          CNTW           = 24,
  parameter logic [31:0] FIFO_PORT_ADDR = 32'h0001_0040,
  localparam int         CW             = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_we_i,
  input  logic [1:0]      host_sel_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [15:0]     status_o,
  output logic [15:0]     len_o,
  output logic            anomaly_o,
  input  logic [1:0]      chan_mode_i,
  input  logic            chan_en_i,
  input  logic [AW-1:0]   chan_src_i,
  input  logic            chan_load_i,
  input  logic [AW-1:0]   chan_dst_i,
  input  logic [CNTW-1:0] chan_cnt_i,
  input  logic            chan_kick_i,
  output logic [AW-1:0]   chan_dst_o,
  output logic [CNTW-1:0] chan_cnt_o,
  output logic            chan_end_o,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_data_o
);
  logic ctrl_wr, len_wr, data_wr, armed, src_hit;
  logic push, pop, finish, busy, last, full;
  logic [CW-1:0] fill;
  logic [15:0] len_q, len_after;
  logic en_q, dir_q, anomaly_q;

  assign ctrl_wr = host_we_i && (host_sel_i == SEL_CTRL);
  assign len_wr  = host_we_i && (host_sel_i == SEL_LEN);
  assign data_wr = host_we_i && (host_sel_i == SEL_DATA);
  assign armed   = (chan_mode_i == MODE_HOST_REQ) && chan_en_i;
  assign src_hit = chan_src_i == AW'(FIFO_PORT_ADDR);
  assign push    = data_wr && en_q && !busy && !full;

  hfb_word_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(host_wdata_i),
    .pop_i(pop), .clear_i(finish),
    .fill_o(fill), .head_o(mem_data_o), .last_o(last), .full_o(full)
  );

  hfb_chan_regs #(.AW(AW), .CNTW(CNTW)) u_chan (
    .clk_i, .rst_ni,
    .load_i(chan_load_i), .dst_i(chan_dst_i), .cnt_i(chan_cnt_i),
    .step_i(pop), .finish_i(finish),
    .dst_o(chan_dst_o), .cnt_o(chan_cnt_o), .end_o(chan_end_o)
  );

  hfb_drain_fsm #(.CW(CW), .CNTW(CNTW)) u_fsm (
    .clk_i, .rst_ni,
    .push_i(push), .fill_i(fill), .kick_i(chan_kick_i),
    .src_hit_i(src_hit), .armed_i(armed), .cnt_i(chan_cnt_o),
    .last_i(last), .mem_ready_i,
    .busy_o(busy), .mem_valid_o, .pop_o(pop), .finish_o(finish)
  );

  assign len_after = pop ? len_q - 16'd1 : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= '0;
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      anomaly_q <= 1'b0;
    end else begin
      anomaly_q <= data_wr && !en_q;
      if (len_wr) len_q <= {host_wdata_i[15:2], 2'b00};
      if (pop) len_q <= len_after;
      if (ctrl_wr) begin
        en_q  <= host_wdata_i[0];
        dir_q <= host_wdata_i[1];
      end
      if (finish && len_after == '0) en_q <= 1'b0;
    end
  end

  always_comb begin
    status_o                = '0;
    status_o[STAT_EN_BIT]   = en_q;
    status_o[STAT_DIR_BIT]  = dir_q;
    status_o[STAT_FULL_BIT] = full;
  end

  assign len_o      = len_q;
  assign anomaly_o  = anomaly_q;
  assign mem_addr_o = chan_dst_o;
endmodule

// File: rtl/hfifo_bridge_chk.sv
module hfifo_bridge_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CNTW  = 24,
  parameter int CW    = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            host_we_i,
  input logic [1:0]      host_sel_i,
  input logic [DW-1:0]   host_wdata_i,
  input logic [15:0]     status_o,
  input logic [15:0]     len_o,
  input logic            anomaly_o,
  input logic [CNTW-1:0] chan_cnt_o,
  input logic            chan_end_o,
  input logic            mem_valid_o,
  input logic            mem_ready_i,
  input logic [AW-1:0]   mem_addr_o,
  input logic [DW-1:0]   mem_data_o,
  input logic            busy,
  input logic            push,
  input logic [CW-1:0]   fill
);
  assert_len_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_sel_i == 2'd1 && !busy) |=>
      (len_o[1:0] == 2'b00 && len_o[15:2] == $past(host_wdata_i[15:2])));

  assert_anomaly_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_sel_i == 2'd2 && !status_o[0]) |=> anomaly_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  assert_no_req_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> chan_cnt_o != '0);

  assert_full_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fill == CW'(DEPTH - 1)) |=> status_o[7]);

  assert_en_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(status_o[0]) && !$past(host_we_i && host_sel_i == 2'd0)) |-> len_o == '0);

  assert_end_cnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chan_end_o) |-> chan_cnt_o == '0);
endmodule

bind hfifo_bridge hfifo_bridge_chk #(
  .DW(DW), .DEPTH(DEPTH), .AW(AW), .CNTW(CNTW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_we_i(host_we_i), .host_sel_i(host_sel_i), .host_wdata_i(host_wdata_i),
  .status_o(status_o), .len_o(len_o), .anomaly_o(anomaly_o),
  .chan_cnt_o(chan_cnt_o), .chan_end_o(chan_end_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .busy(busy), .push(push), .fill(fill)
);

// File: tb/hfifo_bridge_tb.sv
`timescale 1ns/1ps
module hfifo_bridge_tb;
  localparam logic [31:0] PORT = 32'h0001_0040;

  typedef struct packed {
    logic [15:0] len;
    logic [23:0] cnt;
    logic [31:0] dst;
    logic        stall;
    logic [3:0]  exp_n;
    logic [15:0] exp_len;
    logic        exp_en;
    logic        exp_end;
  } row_t;

  // R6/R8/R9 vectors: empty-FIFO stop, length runs out, count runs out
  localparam row_t ROWS [4] = '{
    '{16'h0008, 24'd8, 32'h2000_0000, 1'b0, 4'd4, 16'h0004, 1'b1, 1'b0},
    '{16'h0004, 24'd8, 32'h2000_0100, 1'b1, 4'd4, 16'h0000, 1'b0, 1'b0},
    '{16'h0008, 24'd2, 32'h2000_0200, 1'b0, 4'd2, 16'h0006, 1'b1, 1'b1},
    '{16'h0013, 24'd4, 32'h2000_0300, 1'b1, 4'd4, 16'h000C, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = 2'd3;
  logic [15:0] host_wdata = '0;
  logic [15:0] status, len;
  logic anomaly;
  logic [1:0] chan_mode = 2'd0;
  logic chan_en = 1'b0, chan_load = 1'b0, chan_kick = 1'b0;
  logic [31:0] chan_src = '0, chan_dst = '0, chan_dst_q, mem_addr;
  logic [23:0] chan_cnt = '0, chan_cnt_q;
  logic chan_end, mem_valid, mem_ready = 1'b1, stall_mode = 1'b0;
  logic [15:0] mem_data;
  logic [31:0] log_addr [$];
  logic [15:0] log_data [$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hfifo_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_sel_i(host_sel), .host_wdata_i(host_wdata),
    .status_o(status), .len_o(len), .anomaly_o(anomaly),
    .chan_mode_i(chan_mode), .chan_en_i(chan_en), .chan_src_i(chan_src),
    .chan_load_i(chan_load), .chan_dst_i(chan_dst), .chan_cnt_i(chan_cnt),
    .chan_kick_i(chan_kick),
    .chan_dst_o(chan_dst_q), .chan_cnt_o(chan_cnt_q), .chan_end_o(chan_end),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  // memory sink model: log handshakes, optionally stall every other cycle
  always @(negedge clk) begin
    if (mem_valid && mem_ready) begin
      log_addr.push_back(mem_addr);
      log_data.push_back(mem_data);
    end
    mem_ready <= stall_mode ? ~mem_ready : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_sel = 2'd3;
  endtask

  task automatic load_chan(input logic [31:0] dst, input logic [23:0] cnt);
    @(negedge clk);
    chan_load = 1'b1; chan_dst = dst; chan_cnt = cnt;
    @(negedge clk);
    chan_load = 1'b0;
  endtask

  task automatic kick(input logic [31:0] src);
    @(negedge clk);
    chan_src = src; chan_kick = 1'b1;
    @(negedge clk);
    chan_kick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 status", {16'h0, status}, 32'h0);
    chk("R1 len", {16'h0, len}, 32'h0);
    chk("R1 cnt", {8'h0, chan_cnt_q}, 32'h0);
    chk("R1 end", {31'h0, chan_end}, 32'h0);
    chk("R1 anomaly", {31'h0, anomaly}, 32'h0);
    chk("R1 valid", {31'h0, mem_valid}, 32'h0);

    // R2 length mask
    host_wr(2'd1, 16'h0027);
    chk("R2 len", {16'h0, len}, 32'h0000_0024);

    // R3 data write without enable
    host_wr(2'd2, 16'hDEAD);
    chk("R3 anomaly", {31'h0, anomaly}, 32'h1);

    // vector table walk (R4 R5 R6 R8 R9)
    for (int r = 0; r < 4; r++) begin
      log_addr.delete(); log_data.delete();
      stall_mode = ROWS[r].stall;
      chan_mode = 2'd1; chan_en = 1'b1; chan_src = '0;
      load_chan(ROWS[r].dst, ROWS[r].cnt);
      host_wr(2'd0, 16'h0001);
      host_wr(2'd1, ROWS[r].len);
      for (int i = 0; i < 4; i++) host_wr(2'd2, 16'hA000 + 16'(r * 16 + i));
      idle(20);
      chk("R5 R6 word count", log_addr.size(), {28'h0, ROWS[r].exp_n});
      for (int i = 0; i < log_addr.size(); i++) begin
        chk("R4 addr", log_addr[i], ROWS[r].dst + 32'(2 * i));
        chk("R4 data (R3 discarded word absent)", {16'h0, log_data[i]},
            {16'h0, 16'hA000 + 16'(r * 16 + i)});
      end
      chk("R6 len", {16'h0, len}, {16'h0, ROWS[r].exp_len});
      chk("R6 cnt", {8'h0, chan_cnt_q}, {8'h0, ROWS[r].cnt - 24'(ROWS[r].exp_n)});
      chk("R8 enable", {31'h0, status[0]}, {31'h0, ROWS[r].exp_en});
      chk("R9 end", {31'h0, chan_end}, {31'h0, ROWS[r].exp_end});
      chk("R7 full cleared", {31'h0, status[7]}, 32'h0);
    end
    stall_mode = 1'b0;

    // R9 load clears end (row 3 left it set)
    log_addr.delete(); log_data.delete();
    chan_mode = 2'd2;
    load_chan(32'h3000_0000, 24'd8);
    chk("R9 end cleared by load", {31'h0, chan_end}, 32'h0);
    host_wr(2'd0, 16'h0001);
    host_wr(2'd1, 16'h0010);
    for (int i = 0; i < 4; i++) host_wr(2'd2, 16'hB000 + 16'(i));
    idle(4);
    chk("R7 full set", {31'h0, status[7]}, 32'h1);
    chk("R5 no drain when mode is not 1", log_addr.size(), 32'd0);
    host_wr(2'd2, 16'hBEEF);
    host_wr(2'd0, 16'h0003);
    chk("R10 full kept", {31'h0, status[7]}, 32'h1);
    chk("R10 dir set", {31'h0, status[1]}, 32'h1);
    chk("R10 enable set", {31'h0, status[0]}, 32'h1);
    chan_mode = 2'd1;
    kick(PORT ^ 32'h4);
    idle(6);
    chk("R11 wrong source no drain", log_addr.size(), 32'd0);
    chk("R11 still full", {31'h0, status[7]}, 32'h1);
    kick(PORT);
    idle(10);
    chk("R11 kick drains", log_addr.size(), 32'd4);
    for (int i = 0; i < log_data.size(); i++) begin
      chk("R7 R11 data order, overflow dropped", {16'h0, log_data[i]}, {16'h0, 16'hB000 + 16'(i)});
      chk("R4 kick addr", log_addr[i], 32'h3000_0000 + 32'(2 * i));
    end
    chk("R7 full cleared after kick drain", {31'h0, status[7]}, 32'h0);
    chk("R6 len after kick drain", {16'h0, len}, 32'h0000_000C);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule